// File: doc/BRIEF.md
# Pipelined Multiply-Add Arithmetic Slice

This block is a signed arithmetic slice for FIR filters and multiply-accumulate loops. Two 18-bit operands can be combined by a pre-adder before they reach an 18x18 signed multiplier. Two symmetric filter taps can therefore share one multiply. The 36-bit product is sign-extended to 48 bits. A post-adder then adds it to an operand picked by a 2-bit mode word. That operand is zero, an external 48-bit C word, the slice's own result register (accumulate) or a 48-bit cascade word from the neighbouring slice.

The mode word, the pre-adder select and the carry input are registered together with the operands, so the function can change on every cycle and stay aligned with its data. The input stage and the product stage are optional pipeline registers, chosen by parameters. The result register is always present, because accumulation needs it. Each stage has its own clock-enable. A synchronous reset clears every stage. The registered result drives both the result port and a cascade output, which feeds the next slice in a chain. The carry out of bit 47 is registered next to the result.

Top module: `mac_slice`

## Requirements
- R1: A high `rst` at a rising edge clears `p_out` and `carry_out` to zero, together with every pipeline stage, regardless of the clock-enables.
- R2: With the default parameters, and with all clock-enables high, inputs that are stable before rising edge k give their result on `p_out` after rising edge k+2, which is the third edge. Before that edge, `p_out` still shows older work.
- R3: Mode code 00 makes the result the two's-complement product of the multiplier operand and `b_in`, sign-extended to 48 bits, plus `carry_in`.
- R4: Pre-adder select code 01 feeds `d_in + a_in` to the multiplier and code 10 feeds `d_in - a_in`. Codes 00 and 11 feed `a_in` unchanged. The pre-adder result is 18 bits and wraps on overflow.
- R5: Mode code 01 makes the result the sign-extended product plus `c_in` plus `carry_in`.
- R6: Mode code 10 makes the result the sign-extended product plus the result register's current value plus `carry_in`. This is accumulation.
- R7: Mode code 11 makes the result the sign-extended product plus `cas_in`, as sampled at the result edge, plus `carry_in`.
- R8: `carry_in` adds one to the post-add. `carry_out` is the carry out of bit 47 of that 48-bit unsigned sum. It is registered with the result.
- R9: `cas_out` equals `p_out` on every cycle.
- R10: While a stage's clock-enable is low, that stage keeps its contents. A low `ce_out` holds `p_out` and `carry_out`. A low `ce_in` freezes the captured operands, modes and carry. A low `ce_mul` freezes the product stage.
- R11: The mode, the pre-adder select, `c_in` and `carry_in` travel through the pipeline with their operands. Changing the mode on consecutive cycles therefore applies each mode to its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of all stages |
| ce_in | input | 1 | Clock-enable of the input stage |
| ce_mul | input | 1 | Clock-enable of the product stage |
| ce_out | input | 1 | Clock-enable of the result register |
| a_in | input | 18 | Pre-adder operand, or direct multiplier operand in bypass |
| d_in | input | 18 | Second pre-adder operand |
| b_in | input | 18 | Multiplier operand |
| c_in | input | 48 | External post-add operand |
| cas_in | input | 48 | Cascade word from the preceding slice |
| op_in | input | 2 | Post-add mode: 00 none, 01 C, 10 accumulate, 11 cascade |
| pre_in | input | 2 | Pre-adder select: 00/11 bypass, 01 add, 10 subtract |
| carry_in | input | 1 | Carry into the post-add |
| p_out | output | 48 | Registered result |
| carry_out | output | 1 | Registered carry out of bit 47 |
| cas_out | output | 48 | Cascade copy of the result for the next slice |

## Verification
Directed patterns come first: small positive products, then a negative operand, then each pre-adder select. These separate the multiply, the sign extension and the add/subtract/bypass choice. A pre-add that overflows to the most negative value shows whether the pre-adder wraps at 18 bits. An all-ones C plus one shows the carry out, and a C plus carry-in shows the carry in. Held accumulation, a cascade word and a sequence with the enables lowered one at a time separate the four post-add sources and the per-stage holds. A long stretch with random operands, modes, enables and occasional resets, checked every cycle against a behavioural model, shows whether the modes and the C operand stay aligned with their data.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

    localparam int OPW   = 18;
    localparam int PRODW = 2 * OPW;
    localparam int PW    = 48;
    localparam int EXTW  = PW - PRODW;

    typedef enum logic [1:0] {
        ZSEL_NONE = 2'b00,
        ZSEL_C    = 2'b01,
        ZSEL_ACC  = 2'b10,
        ZSEL_CASC = 2'b11
    } zsel_e;

    typedef enum logic [1:0] {
        PRE_PASS  = 2'b00,
        PRE_SUM   = 2'b01,
        PRE_DIFF  = 2'b10,
        PRE_PASS2 = 2'b11
    } pre_e;

    typedef struct packed {
        logic [OPW-1:0] a;
        logic [OPW-1:0] d;
        logic [OPW-1:0] b;
        logic [PW-1:0]  c;
        zsel_e          op;
        pre_e           pre;
        logic           cin;
    } in_stage_t;

    typedef struct packed {
        logic [PRODW-1:0] prod;
        logic [PW-1:0]    c;
        zsel_e            op;
        logic             cin;
    } mul_stage_t;

    function automatic logic [PW-1:0] sext_prod(input logic [PRODW-1:0] p);
        return {{EXTW{p[PRODW-1]}}, p};
    endfunction

    function automatic logic [OPW-1:0] pre_combine(input pre_e sel,
                                                   input logic [OPW-1:0] a,
                                                   input logic [OPW-1:0] d);
        logic [OPW-1:0] r;
        case (sel)
            PRE_SUM:  r = d + a;
            PRE_DIFF: r = d - a;
            default:  r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mac_stage_reg.sv
module mac_stage_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN) begin : g_reg
            logic [W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= '0;
                else if (ce)
                    r <= d;
            end
            assign q = r;
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/mac_front.sv
module mac_front
    import mac_slice_pkg::*;
(
    input  in_stage_t  s,
    output mul_stage_t m
);
    logic [OPW-1:0]          pre;
    logic signed [PRODW-1:0] wide_pre;
    logic signed [PRODW-1:0] wide_b;

    always_comb begin
        pre      = pre_combine(s.pre, s.a, s.d);
        wide_pre = PRODW'($signed(pre));
        wide_b   = PRODW'($signed(s.b));
        m.prod   = wide_pre * wide_b;
        m.c      = s.c;
        m.op     = s.op;
        m.cin    = s.cin;
    end
endmodule

// File: rtl/mac_post.sv
module mac_post
    import mac_slice_pkg::*;
(
    input  mul_stage_t    m,
    input  logic [PW-1:0] p_cur,
    input  logic [PW-1:0] casc,
    output logic [PW-1:0] p_nxt,
    output logic          cout_nxt
);
    logic [PW-1:0] z;
    logic [PW:0]   sum;

    always_comb begin
        case (m.op)
            ZSEL_C:    z = m.c;
            ZSEL_ACC:  z = p_cur;
            ZSEL_CASC: z = casc;
            default:   z = '0;
        endcase
        sum      = {1'b0, z} + {1'b0, sext_prod(m.prod)} + {{PW{1'b0}}, m.cin};
        p_nxt    = sum[PW-1:0];
        cout_nxt = sum[PW];
    end
endmodule

// File: rtl/mac_slice.sv
module mac_slice
    import mac_slice_pkg::*;
#(
    parameter bit IN_REG  = 1'b1,
    parameter bit MUL_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_in,
    input  logic          ce_mul,
    input  logic          ce_out,
    input  logic [17:0]   a_in,
    input  logic [17:0]   d_in,
    input  logic [17:0]   b_in,
    input  logic [47:0]   c_in,
    input  logic [47:0]   cas_in,
    input  logic [1:0]    op_in,
    input  logic [1:0]    pre_in,
    input  logic          carry_in,
    output logic [47:0]   p_out,
    output logic          carry_out,
    output logic [47:0]   cas_out
);
    localparam int IN_W  = $bits(in_stage_t);
    localparam int MUL_W = $bits(mul_stage_t);

    in_stage_t     in_raw, in_q;
    mul_stage_t    mul_raw, mul_q;
    logic [PW-1:0] p_reg, p_nxt;
    logic          cout_reg, cout_nxt;

    always_comb begin
        in_raw.a   = a_in;
        in_raw.d   = d_in;
        in_raw.b   = b_in;
        in_raw.c   = c_in;
        in_raw.op  = zsel_e'(op_in);
        in_raw.pre = pre_e'(pre_in);
        in_raw.cin = carry_in;
    end

    mac_stage_reg #(.W(IN_W), .EN(IN_REG)) u_in_stage (
        .clk(clk), .rst(rst), .ce(ce_in), .d(in_raw), .q(in_q)
    );

    mac_front u_front (.s(in_q), .m(mul_raw));

    mac_stage_reg #(.W(MUL_W), .EN(MUL_REG)) u_mul_stage (
        .clk(clk), .rst(rst), .ce(ce_mul), .d(mul_raw), .q(mul_q)
    );

    mac_post u_post (
        .m(mul_q), .p_cur(p_reg), .casc(cas_in),
        .p_nxt(p_nxt), .cout_nxt(cout_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p_reg    <= '0;
            cout_reg <= 1'b0;
        end else if (ce_out) begin
            p_reg    <= p_nxt;
            cout_reg <= cout_nxt;
        end
    end

    assign p_out     = p_reg;
    assign carry_out = cout_reg;
    assign cas_out   = p_reg;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
    import mac_slice_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          ce_out,
    input logic [PW-1:0] p_out,
    input logic          carry_out,
    input mul_stage_t    m_stage
);
    logic [PW-1:0] ext_prod;
    assign ext_prod = sext_prod(m_stage.prod);

    assert_reset_clear_R1: assert property (@(posedge clk)
        ($past(rst) === 1'b1) |-> (p_out == '0 && carry_out == 1'b0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!ce_out) |=> ($stable(p_out) && $stable(carry_out)));

    assert_plain_mult_R3: assert property (@(posedge clk) disable iff (rst)
        (ce_out && m_stage.op == ZSEL_NONE && !m_stage.cin)
            |=> (p_out == $past(ext_prod) && !carry_out));

    assert_acc_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_out && m_stage.op == ZSEL_ACC && m_stage.prod == '0 && !m_stage.cin)
            |=> (p_out == $past(p_out)));
endmodule

bind mac_slice mac_slice_chk u_chk (
    .clk(clk), .rst(rst), .ce_out(ce_out), .p_out(p_out),
    .carry_out(carry_out), .m_stage(mul_q)
);

// File: tb/mac_slice_test.sv
module mac_slice_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_in = 1'b1, ce_mul = 1'b1, ce_out = 1'b1;
    logic [17:0] a_in = '0, d_in = '0, b_in = '0;
    logic [47:0] c_in = '0, cas_in = '0;
    logic [1:0]  op_in = '0, pre_in = '0;
    logic        carry_in = 1'b0;
    logic [47:0] p_out, cas_out;
    logic        carry_out;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    mac_slice uut (
        .clk(clk), .rst(rst), .ce_in(ce_in), .ce_mul(ce_mul), .ce_out(ce_out),
        .a_in(a_in), .d_in(d_in), .b_in(b_in), .c_in(c_in), .cas_in(cas_in),
        .op_in(op_in), .pre_in(pre_in), .carry_in(carry_in),
        .p_out(p_out), .carry_out(carry_out), .cas_out(cas_out)
    );

    // behavioural reference: three stages of plain variables
    logic [17:0] r_a, r_d, r_b;
    logic [47:0] r_c, r_c2, r_p;
    logic [1:0]  r_op, r_pre, r_op2;
    logic        r_cin, r_cin2, r_cout;
    longint      r_prod;

    always @(posedge clk) begin
        logic [47:0]        zz;
        logic [48:0]        ss;
        logic signed [17:0] pv;
        if (rst) begin
            r_a = '0; r_d = '0; r_b = '0; r_c = '0; r_op = '0; r_pre = '0; r_cin = 0;
            r_prod = 0; r_c2 = '0; r_op2 = '0; r_cin2 = 0;
            r_p = '0; r_cout = 0;
        end else begin
            if (ce_out) begin
                case (r_op2)
                    2'd1: zz = r_c2;
                    2'd2: zz = r_p;
                    2'd3: zz = cas_in;
                    default: zz = '0;
                endcase
                ss = {1'b0, zz} + {1'b0, r_prod[47:0]} + {48'd0, r_cin2};
                r_p = ss[47:0];
                r_cout = ss[48];
            end
            if (ce_mul) begin
                if (r_pre == 2'd1)      pv = $signed(r_d + r_a);
                else if (r_pre == 2'd2) pv = $signed(r_d - r_a);
                else                    pv = $signed(r_a);
                r_prod = longint'(pv) * longint'($signed(r_b));
                r_c2 = r_c; r_op2 = r_op; r_cin2 = r_cin;
            end
            if (ce_in) begin
                r_a = a_in; r_d = d_in; r_b = b_in; r_c = c_in;
                r_op = op_in; r_pre = pre_in; r_cin = carry_in;
            end
        end
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp();
        chk(cur_req, p_out, r_p);
        chk(cur_req, {47'd0, carry_out}, {47'd0, r_cout});
        chk("R9", cas_out, p_out);
    endtask

    task automatic tick();
        @(negedge clk);
        cmp();
    endtask

    task automatic drive(input logic [17:0] a, input logic [17:0] d, input logic [17:0] b,
                         input logic [47:0] c, input logic [1:0] op, input logic [1:0] pre,
                         input logic cin);
        a_in = a; d_in = d; b_in = b; c_in = c; op_in = op; pre_in = pre; carry_in = cin;
    endtask

    task automatic zero();
        drive('0, '0, '0, '0, 2'd0, 2'd0, 1'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R2: watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) tick();
        chk("R1", p_out, 48'd0);
        chk("R1", {47'd0, carry_out}, 48'd0);
        @(negedge clk); rst = 1'b0;

        // R2 / R3 latency and plain product
        cur_req = "R3";
        drive(18'd3, '0, 18'd4, '0, 2'd0, 2'd0, 1'b0);
        tick(); zero(); tick();
        chk("R2", p_out, 48'd0);
        tick();
        chk("R2", p_out, 48'd12);
        drive(18'h3FFF9, '0, 18'd6, '0, 2'd0, 2'd0, 1'b0); // -7 * 6
        tick(); zero(); tick(); tick();
        chk("R3", p_out, 48'hFFFF_FFFF_FFD6);

        // R4 pre-adder select codes
        cur_req = "R4";
        drive(18'd2, 18'd5, 18'd3, '0, 2'd0, 2'd1, 1'b0);
        tick(); drive(18'd2, 18'd5, 18'd3, '0, 2'd0, 2'd2, 1'b0);
        tick(); drive(18'd2, 18'd5, 18'd3, '0, 2'd0, 2'd3, 1'b0);
        tick();
        chk("R4", p_out, 48'd21);
        tick();
        chk("R4", p_out, 48'd9);
        drive(18'd1, 18'h1FFFF, 18'd1, '0, 2'd0, 2'd1, 1'b0);
        tick();
        chk("R4", p_out, 48'd6);
        zero(); tick(); tick();
        chk("R4", p_out, 48'hFFFF_FFFE_0000);

        // R5 external C operand
        cur_req = "R5";
        drive(18'd3, '0, 18'd5, 48'd1000, 2'd1, 2'd0, 1'b0);
        tick(); zero(); tick(); tick();
        chk("R5", p_out, 48'd1015);

        // R8 carry out and carry in
        cur_req = "R8";
        drive(18'd1, '0, 18'd1, 48'hFFFF_FFFF_FFFF, 2'd1, 2'd0, 1'b0);
        tick(); drive('0, '0, '0, 48'd5, 2'd1, 2'd0, 1'b1);
        tick(); zero(); tick();
        chk("R8", p_out, 48'd0);
        chk("R8", {47'd0, carry_out}, 48'd1);
        tick();
        chk("R8", p_out, 48'd6);
        chk("R8", {47'd0, carry_out}, 48'd0);

        // R7 cascade input, then R10 result hold
        cur_req = "R7";
        cas_in = 48'd100;
        drive(18'd2, '0, 18'd3, '0, 2'd3, 2'd0, 1'b0);
        tick(); zero(); tick(); tick();
        chk("R7", p_out, 48'd106);
        cur_req = "R10";
        ce_out = 1'b0;
        drive(18'd9, '0, 18'd9, '0, 2'd0, 2'd0, 1'b0);
        repeat (4) tick();
        chk("R10", p_out, 48'd106);
        ce_out = 1'b1; zero(); tick();
        chk("R10", p_out, 48'd81);
        tick(); tick();
        chk("R10", p_out, 48'd0);

        // R10 input stage hold, then mul stage hold
        ce_in = 1'b0;
        drive(18'd4, '0, 18'd4, '0, 2'd0, 2'd0, 1'b0);
        repeat (3) tick();
        chk("R10", p_out, 48'd0);
        ce_in = 1'b1;
        repeat (3) tick();
        chk("R10", p_out, 48'd16);
        ce_mul = 1'b0; zero();
        repeat (3) tick();
        chk("R10", p_out, 48'd16);
        ce_mul = 1'b1; zero();
        repeat (3) tick();
        chk("R10", p_out, 48'd0);

        // R6 accumulation, then R1 mid-run reset
        cur_req = "R6";
        drive(18'd2, '0, 18'd2, '0, 2'd2, 2'd0, 1'b0);
        repeat (4) tick();
        zero(); tick(); tick();
        chk("R6", p_out, 48'd16);
        cur_req = "R1";
        rst = 1'b1; tick();
        chk("R1", p_out, 48'd0);
        rst = 1'b0;

        // R11 mode switching every cycle with random data and enables
        cur_req = "R11";
        for (int i = 0; i < 600; i++) begin
            drive(18'($urandom), 18'($urandom), 18'($urandom),
                  {16'($urandom), 32'($urandom)}, 2'($urandom), 2'($urandom), 1'($urandom));
            cas_in = {16'($urandom), 32'($urandom)};
            ce_in  = ($urandom % 4) != 0;
            ce_mul = ($urandom % 4) != 0;
            ce_out = ($urandom % 4) != 0;
            rst    = ($urandom % 60) == 0;
            tick();
        end
        rst = 1'b0; ce_in = 1'b1; ce_mul = 1'b1; ce_out = 1'b1;
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule